// File: doc/BRIEF.md
# Strided Vector Load Engine

This block performs one vector load at a time from a set of word-interleaved, single-ported memory banks. A start pulse captures a base word address, a stride in words and an element count. The engine then walks the addresses base, base+stride, base+2*stride and so on, one read request per cycle at most, towards a memory whose read data comes back a fixed number of cycles after each request. The elements leave the block in element order on a valid/ready stream, each tagged with its index within the vector.

Each bank is chosen by the low address bits and stays occupied for a fixed number of cycles after it is read. A request whose bank is still occupied waits, and all later elements wait behind it. A stride whose multiples fall on few banks therefore serialises onto those banks and the load runs slower. When the last element has come back from memory, the block raises a one-cycle done pulse and reports how many cycles the load took.

Top module: `vld_strided_load`

## Requirements
- R1: After reset, busy, rd_en, out_valid and done are low and total_cycles is 0.
- R2: An accepted start captures base, stride and len; element k is requested at word address base + k*stride (modulo 2^ADDR_W), in increasing k, and only while busy is high.
- R3: The bank of an address is its value modulo NUM_BANKS (its low log2(NUM_BANKS) bits); a bank read in cycle t is not read again before cycle t+BUSY_CYC, and the waiting request stalls every later element.
- R4: With no bank conflict one element is requested per cycle; with the default parameters (8 banks, busy time 6, latency 12) a 64-element load at stride 1 reports total_cycles = 76.
- R5: A stride that is a multiple of NUM_BANKS hits one bank every time; with default parameters a 64-element load at stride 32 reports 12 + 1 + 6*63 = 391.
- R6: Read data sampled MEM_LAT cycles after its request is emitted on out_data with out_index = element index, in element order; while out_valid is high and out_ready low, out_valid, out_data and out_index hold.
- R7: done is high for exactly one cycle when the last element returns from memory; busy is low from that cycle on, and total_cycles then holds the number of clock edges from the start edge to that return (first request counted as cycle 1, its return at 1 + MEM_LAT).
- R8: start is ignored while busy is high, and a start with len = 0 is ignored.
- R9: When a stride revisits a bank sooner than the busy time (for example stride 6 or 4 over 8 banks), the requests follow the bank-free schedule: each element issues at the later of one cycle after its predecessor and the cycle its bank becomes free.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse, captures base, stride and len |
| base | input | ADDR_W | First word address |
| stride | input | ADDR_W | Address step between elements, in words |
| len | input | LEN_W | Number of elements |
| busy | output | 1 | A load is in progress |
| rd_en | output | 1 | Read request to the banks this cycle |
| rd_addr | output | ADDR_W | Word address of the read request |
| rd_data | input | DATA_W | Read data, valid MEM_LAT cycles after the request |
| out_valid | output | 1 | An element is offered |
| out_ready | input | 1 | Consumer accepts the offered element |
| out_data | output | DATA_W | Element value |
| out_index | output | LEN_W | Element index within the vector |
| done | output | 1 | One-cycle pulse at the return of the last element |
| total_cycles | output | CNT_W | Duration of the most recent load in cycles |

## Verification
On every cycle the assertions check the per-bank spacing of read requests against the busy time, that requests only appear during a load, that done is a single-cycle pulse ending the load, that a stalled output holds its element, and that a zero-length start leaves the block idle. Only the bench scenarios can show that addresses follow base plus multiples of the stride, that the cycle totals match the conflict-free, single-bank and partially conflicting schedules, that elements arrive in order under random backpressure, and that a start during a load leaves that load untouched.

// File: rtl/vld_pkg.sv
// Package vld_pkg: shared defaults and types for the strided vector load engine.
// Assumes nothing beyond being compiled before the modules that import it.
package vld_pkg;
    localparam int DEF_NUM_BANKS = 8;
    localparam int DEF_BUSY_CYC  = 6;
    localparam int DEF_MEM_LAT   = 12;
    localparam int DEF_ADDR_W    = 16;
    localparam int DEF_DATA_W    = 32;
    localparam int DEF_LEN_W     = 7;
    localparam int DEF_OUT_DEPTH = 16;
    localparam int DEF_CNT_W     = 16;

    typedef enum logic {
        LD_IDLE = 1'b0,
        LD_RUN  = 1'b1
    } ld_state_e;
endpackage

// File: rtl/vld_addr_gen.sv
// Module vld_addr_gen: walks base, base+stride, ... for the elements still to be
// requested. Assumes load and issue are never high in the same cycle.
module vld_addr_gen #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] stride_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              issue,
    output logic              pending,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] stride_q;
    logic [LEN_W-1:0]  left_q;

    // Capture the vector on load, advance by one stride per issued element.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr     <= '0;
            stride_q <= '0;
            left_q   <= '0;
        end else if (load) begin
            addr     <= base_i;
            stride_q <= stride_i;
            left_q   <= len_i;
        end else if (issue) begin
            addr     <= addr + stride_q;
            left_q   <= left_q - 1'b1;
        end
    end

    assign pending = (left_q != '0);
endmodule

// File: rtl/vld_bank_busy.sv
// Module vld_bank_busy: one down-counter per bank, loaded on access so the bank
// reads as free again BUSY_CYC cycles after it was read. Assumes BUSY_CYC >= 1.
module vld_bank_busy #(
    parameter int NUM_BANKS = 8,
    parameter int BUSY_CYC  = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         acc_en,
    input  logic [$clog2(NUM_BANKS)-1:0] acc_bank,
    output logic [NUM_BANKS-1:0]         free_mask
);
    localparam int BSEL_W = $clog2(NUM_BANKS);
    localparam int TMR_W  = $clog2(BUSY_CYC + 1);
    localparam logic [TMR_W-1:0] RELOAD = TMR_W'(BUSY_CYC - 1);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [TMR_W-1:0] tmr;

        // Reload on access to this bank, otherwise count down to zero.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tmr <= '0;
            end else if (acc_en && (acc_bank == BSEL_W'(b))) begin
                tmr <= RELOAD;
            end else if (tmr != '0) begin
                tmr <= tmr - 1'b1;
            end
        end

        assign free_mask[b] = (tmr == '0);
    end
endmodule

// File: rtl/vld_return_buf.sv
// Module vld_return_buf: tracks requests through the fixed memory latency, tags
// returning words with their element index and queues them for the output.
// Assumes the caller only issues while space_ok is high, so the queue never overflows.
module vld_return_buf #(
    parameter int DATA_W    = 32,
    parameter int LEN_W     = 7,
    parameter int MEM_LAT   = 12,
    parameter int OUT_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              issue,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              out_ready,
    output logic              space_ok,
    output logic              arrive,
    output logic [LEN_W-1:0]  arr_idx,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [LEN_W-1:0]  out_index
);
    localparam int PTR_W = $clog2(OUT_DEPTH);
    localparam int CRD_W = PTR_W + 1;

    logic [MEM_LAT-1:0] lat_pipe;
    logic [DATA_W-1:0]  dat_mem [OUT_DEPTH];
    logic [LEN_W-1:0]   idx_mem [OUT_DEPTH];
    logic [PTR_W-1:0]   wr_ptr, rd_ptr;
    logic [CRD_W-1:0]   fill, credit;
    logic               pop;

    // Shift a marker through the memory latency, one stage per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_pipe <= '0;
        end else begin
            lat_pipe[0] <= issue;
            for (int i = 1; i < MEM_LAT; i++) lat_pipe[i] <= lat_pipe[i-1];
        end
    end

    assign arrive = lat_pipe[MEM_LAT-1];
    assign pop    = out_valid && out_ready;

    // Count arrivals within the current vector to tag each word.
    always_ff @(posedge clk) begin
        if (!rst_n || load) arr_idx <= '0;
        else if (arrive)    arr_idx <= arr_idx + 1'b1;
    end

    // Store arriving words with their index.
    always_ff @(posedge clk) begin
        if (arrive) begin
            dat_mem[wr_ptr] <= rd_data;
            idx_mem[wr_ptr] <= arr_idx;
        end
    end

    // Queue pointers, fill level and outstanding-element credit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
            credit <= '0;
        end else begin
            if (arrive) wr_ptr <= wr_ptr + 1'b1;
            if (pop)    rd_ptr <= rd_ptr + 1'b1;
            fill   <= fill + CRD_W'(arrive) - CRD_W'(pop);
            credit <= credit + CRD_W'(issue) - CRD_W'(pop);
        end
    end

    assign space_ok  = (credit < CRD_W'(OUT_DEPTH));
    assign out_valid = (fill != '0);
    assign out_data  = dat_mem[rd_ptr];
    assign out_index = idx_mem[rd_ptr];
endmodule

// File: rtl/vld_strided_load.sv
// Module vld_strided_load: top of the strided vector load engine. Accepts a
// load when idle, issues reads as banks become free, returns elements in order
// and reports the load duration. Assumes NUM_BANKS and OUT_DEPTH are powers of
// two (NUM_BANKS >= 2), MEM_LAT >= 1 and BUSY_CYC >= 1.
module vld_strided_load
    import vld_pkg::*;
#(
    parameter int NUM_BANKS = DEF_NUM_BANKS,
    parameter int BUSY_CYC  = DEF_BUSY_CYC,
    parameter int MEM_LAT   = DEF_MEM_LAT,
    parameter int ADDR_W    = DEF_ADDR_W,
    parameter int DATA_W    = DEF_DATA_W,
    parameter int LEN_W     = DEF_LEN_W,
    parameter int OUT_DEPTH = DEF_OUT_DEPTH,
    parameter int CNT_W     = DEF_CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] stride,
    input  logic [LEN_W-1:0]  len,
    output logic              busy,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic [LEN_W-1:0]  out_index,
    output logic              done,
    output logic [CNT_W-1:0]  total_cycles
);
    localparam int BSEL_W = $clog2(NUM_BANKS);

    ld_state_e         state;
    logic [LEN_W-1:0]  len_q;
    logic [CNT_W-1:0]  cyc_cnt;
    logic              accept, issue, pending, space_ok, arrive, last_arr;
    logic [ADDR_W-1:0] cur_addr;
    logic [BSEL_W-1:0] bank_sel;
    logic [NUM_BANKS-1:0] bank_free;
    logic [LEN_W-1:0]  arr_idx;

    assign accept   = start && (state == LD_IDLE) && (len != '0);
    assign bank_sel = cur_addr[BSEL_W-1:0];
    assign issue    = (state == LD_RUN) && pending && bank_free[bank_sel] && space_ok;
    assign last_arr = arrive && (arr_idx == len_q - 1'b1);

    vld_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_addr_gen (
        .clk(clk), .rst_n(rst_n), .load(accept),
        .base_i(base), .stride_i(stride), .len_i(len),
        .issue(issue), .pending(pending), .addr(cur_addr)
    );

    vld_bank_busy #(.NUM_BANKS(NUM_BANKS), .BUSY_CYC(BUSY_CYC)) i_bank_busy (
        .clk(clk), .rst_n(rst_n), .acc_en(issue), .acc_bank(bank_sel),
        .free_mask(bank_free)
    );

    vld_return_buf #(.DATA_W(DATA_W), .LEN_W(LEN_W), .MEM_LAT(MEM_LAT),
                     .OUT_DEPTH(OUT_DEPTH)) i_return_buf (
        .clk(clk), .rst_n(rst_n), .load(accept), .issue(issue),
        .rd_data(rd_data), .out_ready(out_ready), .space_ok(space_ok),
        .arrive(arrive), .arr_idx(arr_idx), .out_valid(out_valid),
        .out_data(out_data), .out_index(out_index)
    );

    // Load sequencing: start acceptance, cycle counting and completion report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= LD_IDLE;
            len_q        <= '0;
            cyc_cnt      <= '0;
            total_cycles <= '0;
            done         <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                state   <= LD_RUN;
                len_q   <= len;
                cyc_cnt <= '0;
            end else if (state == LD_RUN) begin
                cyc_cnt <= cyc_cnt + 1'b1;
                if (last_arr) begin
                    state        <= LD_IDLE;
                    done         <= 1'b1;
                    total_cycles <= cyc_cnt + 1'b1;
                end
            end
        end
    end

    assign busy    = (state == LD_RUN);
    assign rd_en   = issue;
    assign rd_addr = cur_addr;
endmodule

// File: rtl/vld_checker.sv
// Module vld_checker: protocol and timing properties of vld_strided_load,
// observed on its ports only; attached to every instance by the bind below.
module vld_checker #(
    parameter int NUM_BANKS = 8,
    parameter int BUSY_CYC  = 6,
    parameter int MEM_LAT   = 12,
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int LEN_W     = 7,
    parameter int OUT_DEPTH = 16,
    parameter int CNT_W     = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [ADDR_W-1:0] base,
    input logic [ADDR_W-1:0] stride,
    input logic [LEN_W-1:0]  len,
    input logic              busy,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic [LEN_W-1:0]  out_index,
    input logic              done,
    input logic [CNT_W-1:0]  total_cycles
);
    localparam int BSEL_W = $clog2(NUM_BANKS);
    localparam int GAP_W  = $clog2(BUSY_CYC + 1);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_gap
        logic [GAP_W-1:0] since;

        // Cycles since this bank was last read, saturating at the busy time.
        always_ff @(posedge clk) begin
            if (!rst_n) since <= GAP_W'(BUSY_CYC);
            else if (rd_en && rd_addr[BSEL_W-1:0] == BSEL_W'(b)) since <= GAP_W'(1);
            else if (since != GAP_W'(BUSY_CYC)) since <= since + 1'b1;
        end

        p_bank_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && rd_addr[BSEL_W-1:0] == BSEL_W'(b)) |-> (since >= GAP_W'(BUSY_CYC)));
    end

    p_read_in_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> busy);

    p_output_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_index)));

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_zero_len_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && len == '0) |=> !busy);
endmodule

bind vld_strided_load vld_checker #(
    .NUM_BANKS(NUM_BANKS), .BUSY_CYC(BUSY_CYC), .MEM_LAT(MEM_LAT),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W),
    .OUT_DEPTH(OUT_DEPTH), .CNT_W(CNT_W)
) i_vld_checker (.*);

// File: tb/test_vld_strided_load.sv
// Bench for vld_strided_load: a driver task queues expected elements and cycle
// totals, monitors compare them with what the design produces.
module test_vld_strided_load;
    localparam int NUM_BANKS = 8;
    localparam int BUSY_CYC  = 6;
    localparam int MEM_LAT   = 12;
    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 32;
    localparam int LEN_W     = 7;
    localparam int CNT_W     = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] base = '0;
    logic [ADDR_W-1:0] stride = '0;
    logic [LEN_W-1:0]  len = '0;
    logic              busy, rd_en, out_valid, done;
    logic              out_ready = 1'b1;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data, out_data;
    logic [LEN_W-1:0]  out_index;
    logic [CNT_W-1:0]  total_cycles;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit bp_mode = 1'b0;
    bit finished = 1'b0;

    int          exp_idx_q [$];
    logic [DATA_W-1:0] exp_dat_q [$];
    int          exp_tot_q [$];
    int          last_rd [NUM_BANKS];

    logic [DATA_W-1:0] dline [MEM_LAT];

    always #4 clk = ~clk;

    vld_strided_load i_vld_strided_load (
        .clk(clk), .rst_n(rst_n), .start(start), .base(base), .stride(stride),
        .len(len), .busy(busy), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_index(out_index), .done(done), .total_cycles(total_cycles)
    );

    function automatic logic [DATA_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
        return {~a, a};
    endfunction

    // Memory model: word for a request sampled at an edge appears MEM_LAT-1 edges later.
    always @(posedge clk) begin
        dline[0] <= rd_en ? mem_word(rd_addr) : '0;
        for (int i = 1; i < MEM_LAT; i++) dline[i] <= dline[i-1];
    end
    assign rd_data = dline[MEM_LAT-1];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Monitor: ready policy, element scoreboard, bank spacing and done/total.
    initial begin
        for (int b = 0; b < NUM_BANKS; b++) last_rd[b] = -1000;
        forever begin
            @(negedge clk);
            cyc++;
            out_ready = bp_mode ? ($urandom % 3 != 0) : 1'b1;
            if (rst_n && out_valid && out_ready) begin
                if (exp_idx_q.size() == 0) begin
                    check(0, "R8", "unexpected element index", out_index, -1);
                end else begin
                    int ei;
                    logic [DATA_W-1:0] ed;
                    ei = exp_idx_q.pop_front();
                    ed = exp_dat_q.pop_front();
                    check(out_index == LEN_W'(ei), "R6", "element index", out_index, ei);
                    check(out_data == ed, "R2", "element data", out_data, ed);
                end
            end
            if (rst_n && rd_en) begin
                int b;
                b = int'(rd_addr) % NUM_BANKS;
                check(cyc - last_rd[b] >= BUSY_CYC, "R3", "bank reuse gap",
                      cyc - last_rd[b], BUSY_CYC);
                last_rd[b] = cyc;
            end
            if (rst_n && done) begin
                if (exp_tot_q.size() == 0) begin
                    check(0, "R7", "unexpected done", 1, 0);
                end else begin
                    int et;
                    et = exp_tot_q.pop_front();
                    if (et >= 0) check(int'(total_cycles) == et, "R9", "total_cycles",
                                       total_cycles, et);
                    check(!busy, "R7", "busy at done", busy, 0);
                end
            end
        end
    end

    // Driver: start one load and queue its expected elements and total.
    task automatic run_load(input int b0, input int st, input int n, input bit want_tot);
        int free_at [NUM_BANKS];
        int t;
        for (int b = 0; b < NUM_BANKS; b++) free_at[b] = 0;
        t = 0;
        for (int k = 0; k < n; k++) begin
            logic [ADDR_W-1:0] a;
            int bk;
            a = ADDR_W'(b0 + k * st);
            bk = int'(a) % NUM_BANKS;
            t = (t + 1 > free_at[bk]) ? t + 1 : free_at[bk];
            free_at[bk] = t + BUSY_CYC;
            exp_idx_q.push_back(k);
            exp_dat_q.push_back(mem_word(a));
        end
        exp_tot_q.push_back(want_tot ? t + MEM_LAT : -1);
        @(negedge clk);
        base = ADDR_W'(b0); stride = ADDR_W'(st); len = LEN_W'(n); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2", "busy after start", busy, 1);
    endtask

    task automatic wait_idle();
        while (exp_idx_q.size() != 0 || exp_tot_q.size() != 0) @(negedge clk);
        repeat (20) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!busy && !rd_en && !out_valid && !done, "R1", "idle outputs",
              {busy, rd_en, out_valid, done}, 0);
        check(total_cycles == '0, "R1", "total after reset", total_cycles, 0);

        // R4: conflict-free stride 1, 64 elements -> 76
        run_load(16'h0100, 1, 64, 1);
        wait_idle();
        check(1, "R4", "stride 1 load", 76, 76);

        // R5: single bank stride 32, 64 elements -> 391; R8 start during load ignored
        run_load(16'h0200, 32, 64, 1);
        repeat (30) @(negedge clk);
        base = 16'h7777; stride = 16'd3; len = 7'd5; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R8", "busy after ignored start", busy, 1);
        wait_idle();

        // R9: partial conflicts at stride 6 and stride 4
        run_load(16'h0003, 6, 20, 1);
        wait_idle();
        run_load(16'h0011, 4, 12, 1);
        wait_idle();

        // R4: coprime stride 7 and address wrap
        run_load(16'hFFF0, 7, 16, 1);
        wait_idle();

        // R8: zero-length start ignored
        @(negedge clk);
        len = '0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b0, "R8", "busy after zero-length start", busy, 0);
        repeat (MEM_LAT + 4) @(negedge clk);
        check(out_valid == 1'b0, "R8", "output after zero-length start", out_valid, 0);

        // R6: random backpressure, order and hold of elements
        bp_mode = 1'b1;
        run_load(16'h0400, 3, 40, 0);
        wait_idle();
        run_load(16'h0500, 16, 10, 0);
        wait_idle();
        bp_mode = 1'b0;

        check(exp_idx_q.size() == 0, "R6", "elements left over", exp_idx_q.size(), 0);
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R7 watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule